// File: doc/BRIEF.md
# Prioritized interrupt level resolver

This block takes a word of pending software interrupt requests and a word of external interrupt lines. It reduces them to one priority level and a summary mask. A software request in the software field gets a level one above its position inside that field. An external line gets a level equal to its own bit index. Any pending external line takes precedence over every software request, because external levels sit above the whole software range. The summary mask keeps every pending in-field bit at its original position.

The resolved level is compared with the processor's current 5-bit priority level. An evaluation happens only in a cycle where the re-check flag is armed. The flag is armed out of reset and disarms after every evaluation. It re-arms only when a return-from-privileged-code strobe arrives while the privileged-mode input is high. When an armed evaluation finds a level that is nonzero and strictly above the current priority, the block does three things at the next clock edge: it loads the summary register, loads the interrupt ID register and pulses the trap output for one clock.

Top module: `irq_level_resolver`

## Requirements
- R1: A pending software bit at index i, with 4 <= i <= 18, yields level i-3. Among software bits the highest pending index sets the level, so bit 4 alone gives level 1 and bit 18 gives level 15.
- R2: A pending external line at index i, with 20 <= i <= 30, yields level i. When any such line is pending, the highest pending external index sets the level, whatever software bits are pending.
- R3: The summary is the OR of the pending software bits 4..18 and the pending external bits 20..30, each at its own bit position. Request bits outside those two fields change neither the level nor the summary.
- R4: A trap is accepted only when the resolved level is nonzero and strictly greater than `cur_ipl`. A level equal to `cur_ipl` gives no trap.
- R5: On an accepted trap, `isr_q` takes the summary and `intid_q` takes the level. Without an accepted trap, both hold their values.
- R6: An evaluation takes place only in a cycle where the re-check flag is armed, and the flag is disarmed after every evaluation. While it is disarmed, no trap is produced, even with requests pending.
- R7: The flag is armed for the next cycle only when `ret_strobe` and `priv_mode` are both high. A strobe with `priv_mode` low does not arm it.
- R8: `trap` is registered. It is high for exactly the one clock that follows the accepting cycle.
- R9: After reset, `trap` is 0, `isr_q` is 0, `intid_q` is 0 and the flag is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 32 | Software request word; only bits 4..18 are used |
| ext_req | input | 32 | External interrupt lines; only bits 20..30 are used |
| cur_ipl | input | 5 | Current processor priority level |
| ret_strobe | input | 1 | Return from privileged code executed |
| priv_mode | input | 1 | Processor is in privileged mode |
| trap | output | 1 | One-clock trap request |
| isr_q | output | 32 | Interrupt summary register |
| intid_q | output | 5 | Interrupt ID register |

## Verification
A lone software bit 4 must give level 1. Adding an external line on top of it shows that external lines override software, and that the summary carries both bits. A level equal to the current priority separates a strict compare from a non-strict one. Requests placed only in bits outside the fields show whether those bits are masked. Holding requests while the flag is disarmed, or strobing the return while not privileged, shows whether the arming gate works. Random words with random priority and random arming, compared against a reference model, cover mixed patterns with several bits pending in both fields.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned IRQ_VEC_W  = 32;
  localparam int unsigned IRQ_SW_LO  = 4;
  localparam int unsigned IRQ_SW_HI  = 18;
  localparam int unsigned IRQ_EXT_LO = 20;
  localparam int unsigned IRQ_EXT_HI = 30;
  localparam int unsigned IRQ_LVL_W  = 5;
endpackage

// File: rtl/irq_hi_scan.sv
module irq_hi_scan #(
  parameter int unsigned N     = 15,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Ascending scan: the last set bit seen is the highest one.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_src_field.sv
module irq_src_field #(
  parameter int unsigned VEC_W   = 32,
  parameter int unsigned LO      = 4,
  parameter int unsigned HI      = 18,
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned LVL_OFS = 1
) (
  input  logic [VEC_W-1:0] vec,
  output logic             found,
  output logic [LVL_W-1:0] level,
  output logic [VEC_W-1:0] part
);
  localparam int unsigned N     = HI - LO + 1;
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  irq_hi_scan #(.N(N), .IDX_W(IDX_W)) u_scan (
    .req   (vec[HI:LO]),
    .found (found),
    .idx   (idx)
  );

  assign level = found ? (LVL_W'(idx) + LVL_W'(LVL_OFS)) : '0;

  // Per-bit field mask keeps pending bits at their own position.
  for (genvar b = 0; b < VEC_W; b++) begin : g_mask
    localparam bit IN_FIELD = (b >= LO) && (b <= HI);
    assign part[b] = vec[b] & IN_FIELD;
  end
endmodule

// File: rtl/irq_recheck_flag.sv
module irq_recheck_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_strobe,
  input  logic priv_mode,
  output logic armed
);
  logic armed_d;

  // Evaluation disarms every cycle; a valid privileged return re-arms.
  always_comb armed_d = ret_strobe & priv_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b1;
    else        armed <= armed_d;
  end

  AST_NO_ARM_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_mode |=> !armed); // R7
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned VEC_W  = IRQ_VEC_W,
  parameter int unsigned SW_LO  = IRQ_SW_LO,
  parameter int unsigned SW_HI  = IRQ_SW_HI,
  parameter int unsigned EXT_LO = IRQ_EXT_LO,
  parameter int unsigned EXT_HI = IRQ_EXT_HI,
  parameter int unsigned LVL_W  = IRQ_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] sw_req,
  input  logic [VEC_W-1:0] ext_req,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic             ret_strobe,
  input  logic             priv_mode,
  output logic             trap,
  output logic [VEC_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);
  logic             sw_found, ext_found, armed, accept;
  logic [LVL_W-1:0] sw_lvl, ext_lvl, lvl, intid_d;
  logic [VEC_W-1:0] sw_part, ext_part, summary, isr_d;

  irq_src_field #(.VEC_W(VEC_W), .LO(SW_LO), .HI(SW_HI),
                  .LVL_W(LVL_W), .LVL_OFS(1)) u_sw (
    .vec(sw_req), .found(sw_found), .level(sw_lvl), .part(sw_part));

  irq_src_field #(.VEC_W(VEC_W), .LO(EXT_LO), .HI(EXT_HI),
                  .LVL_W(LVL_W), .LVL_OFS(EXT_LO)) u_ext (
    .vec(ext_req), .found(ext_found), .level(ext_lvl), .part(ext_part));

  irq_recheck_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ret_strobe(ret_strobe),
    .priv_mode(priv_mode), .armed(armed));

  always_comb begin
    lvl     = ext_found ? ext_lvl : sw_lvl;
    summary = sw_part | ext_part;
    accept  = armed && (lvl != '0) && (lvl > cur_ipl);
    isr_d   = accept ? summary : isr_q;
    intid_d = accept ? lvl     : intid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap    <= 1'b0;
      isr_q   <= '0;
      intid_q <= '0;
    end else begin
      trap    <= accept;
      isr_q   <= isr_d;
      intid_q <= intid_d;
    end
  end

  AST_EXT_OVER_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_found && sw_found) |-> (lvl > sw_lvl)); // R2
  AST_TRAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(armed)); // R6
  AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (intid_q > $past(cur_ipl))); // R4
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> ($stable(intid_q) && $stable(isr_q))); // R5
  AST_ID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (intid_q != '0)); // R4
endmodule

// File: tb/tb_irq_level_resolver.sv
module tb_irq_level_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sw_req, ext_req;
  logic [4:0]  cur_ipl;
  logic        ret_strobe, priv_mode;
  logic        trap;
  logic [31:0] isr_q;
  logic [4:0]  intid_q;

  int checks = 0, failures = 0;
  bit exp_armed;
  logic [31:0] exp_isr;
  logic [4:0]  exp_id;

  always #2.5 clk = ~clk;

  irq_level_resolver dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
    .cur_ipl(cur_ipl), .ret_strobe(ret_strobe), .priv_mode(priv_mode),
    .trap(trap), .isr_q(isr_q), .intid_q(intid_q));

  function automatic void ref_eval(input logic [31:0] s, input logic [31:0] e,
                                   output logic [4:0] l, output logic [31:0] m);
    l = 0; m = 0;
    for (int i = 4; i <= 18; i++) if (s[i]) begin l = 5'(i - 3); m[i] = 1'b1; end
    for (int i = 20; i <= 30; i++) if (e[i]) begin l = 5'(i); m[i] = 1'b1; end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, clock once, check at following negedge.
  task automatic step(input logic [31:0] s, input logic [31:0] e, input logic [4:0] ipl,
                      input bit ret, input bit priv, input string req);
    logic [4:0] l; logic [31:0] m; bit acc;
    sw_req = s; ext_req = e; cur_ipl = ipl; ret_strobe = ret; priv_mode = priv;
    ref_eval(s, e, l, m);
    acc = exp_armed && (l != 0) && (l > ipl);
    if (acc) begin exp_isr = m; exp_id = l; end
    @(negedge clk);
    chk({req, " trap"}, {31'b0, trap}, {31'b0, acc});
    chk({req, " isr_q"}, isr_q, exp_isr);
    chk({req, " intid_q"}, {27'b0, intid_q}, {27'b0, exp_id});
    exp_armed = ret && priv;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sw_req = 0; ext_req = 0; cur_ipl = 0; ret_strobe = 0; priv_mode = 0;
    exp_armed = 1; exp_isr = 0; exp_id = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset trap", {31'b0, trap}, 32'd0);
    chk("R9 reset isr", isr_q, 32'd0);
    chk("R9 reset intid", {27'b0, intid_q}, 32'd0);
    rst_n = 1'b1;
    // R9 flag armed at reset, R1 bit 4 alone -> level 1, R8 pulse
    step(32'h10, 0, 0, 1, 1, "R1 R9 sw bit4 level1");
    step(32'h10, 32'h0200_0000, 0, 1, 1, "R2 ext25 overrides sw4");
    step(32'h0, 0, 0, 1, 1, "R8 trap drops with nothing pending");
    step(32'h0004_0000, 0, 5'd15, 1, 1, "R4 equal ipl no trap");
    step(32'h0004_0000, 0, 5'd14, 1, 1, "R1 sw bit18 level15");
    step(32'h8000_000F, 32'h800F_FFFF, 0, 1, 1, "R3 out-of-field bits ignored");
    step(32'h0000_0110, 32'h4010_0000, 0, 0, 1, "R3 R2 summary mixed ext30");
    step(32'h0000_0110, 32'h4010_0000, 0, 1, 1, "R6 disarmed no trap");
    step(32'h0000_0020, 0, 0, 1, 0, "R6 armed again sw5");
    step(32'h0000_0020, 0, 0, 1, 1, "R7 unprivileged return does not arm");
    step(32'h0010_0000, 0, 5'd19, 1, 1, "R2 ext20 level20 above 19");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] s, e; logic [4:0] ipl;
      s = $urandom() & $urandom();
      e = ($urandom_range(0, 1) == 1) ? ($urandom() & $urandom() & $urandom()) : 0;
      ipl = 5'($urandom_range(0, 31));
      step(s, e, ipl, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule